// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a bit-serial stream into an eight-bit parallel word. It has two stages of state. A shift chain takes one serial bit on each rising edge of a shift strobe. A holding register copies the whole chain on each rising edge of a separate store strobe. The holding register drives the parallel outputs. A clear input empties only the shift chain, and an output-enable input only gates the drive of the parallel pads. The last shift stage is also brought out as a serial output, so several copies can be chained into one longer register.

Everything runs in one system-clock domain. The two strobe inputs, the serial data input and the clear are each passed through a two-flop synchroniser. The strobes are then edge-detected, so every strobe pulse must stay high and then low for at least two system clocks. The serial data path is not a valid/ready stream. A bit is taken on every detected shift edge and there is no back-pressure, so the upstream driver alone sets the pace. The pads are modelled as a data vector plus a per-bit drive flag, and the enclosing level builds the tri-state buffers from those.

Top module: `lsr_latched_sipo`

## Requirements
- R1: On each detected rising edge of the shift strobe, the synchronised serial input enters stage 0 and every stage n moves to stage n+1, toward stage 7.
- R2: On each detected rising edge of the store strobe, all eight stages are copied into the holding register, and parallel output bit n equals stage n. Bit 0 is the stage fed by the serial input. After reset both registers hold zero.
- R3: The holding register, and so the parallel data, changes only on a detected store edge.
- R4: While the synchronised clear is low, the shift stages are held at zero and shift edges have no effect.
- R5: Clear leaves the holding register and the parallel data unchanged.
- R6: A store edge after a clear loads all zeros into the holding register.
- R7: When the output-enable input is high, all eight drive flags are 0. When it is low, all eight are 1. The flags follow the input with no clock delay.
- R8: The output-enable input never alters the shift stages or the holding register, and the serial output does not depend on it.
- R9: The serial output always shows stage 7, so after a shift edge it shows the value that stage 6 held before that edge.
- R10: When shift and store edges arrive in the same cycle, the holding register captures the stages as they were before that shift.
- R11: A strobe input first sampled high on a system-clock edge takes effect on the registers at the third rising edge, counting that first edge as one.
- R12: With two instances chained, serial output to serial input, and sharing their strobes, sixteen shifts followed by one store leave the first eight bits shifted in on the downstream instance and the last eight on the upstream one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, clears all state |
| ser_in | input | 1 | Serial data input, taken on shift edges |
| sh_strobe | input | 1 | Shift strobe, asynchronous, acts on its rising edge |
| st_strobe | input | 1 | Store strobe, asynchronous, acts on its rising edge |
| clr_n | input | 1 | Active-low clear of the shift stages |
| oe_n | input | 1 | Active-low parallel output enable |
| par_q | output | WIDTH | Holding register contents toward the pads |
| par_drive | output | WIDTH | Per-bit pad drive flag, 0 means high impedance |
| ser_out | output | 1 | Last shift stage, for chaining |

## Verification
A corrupted shift stage shows up on the serial output once it has walked to stage 7, which takes at most eight shift edges. It also shows up on the parallel data at the next store edge, three system clocks after the strobe is sampled. A corrupted holding register shows up at once on the parallel data and stays there until the next store. The bench sweeps all 256 byte values through two chained instances, so every stage and holding bit is driven both high and low. A stuck bit or a wrong stage ordering therefore surfaces within one sixteen-bit word.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;
  // Bit positions inside the bundled synchroniser vector
  localparam int SYNC_W  = 4;
  localparam int IDX_SER = 0;
  localparam int IDX_SH  = 1;
  localparam int IDX_ST  = 2;
  localparam int IDX_CLR = 3;
  // Clear is active low, so its synchroniser resets to the idle (high) level
  localparam logic [SYNC_W-1:0] SYNC_IDLE = 4'b1000;

  typedef struct packed {
    logic store;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/lsr_sync.sv
`timescale 1ns/1ps
module lsr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lsr_rise.sv
`timescale 1ns/1ps
module lsr_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/lsr_shift_chain.sv
`timescale 1ns/1ps
module lsr_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             din,
  output logic [WIDTH-1:0] stages
);
  // Clear wins over a step, so shifts made while clear is held are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stages <= '0;
    else if (clr)  stages <= '0;
    else if (step) stages <= {stages[WIDTH-2:0], din};
  end
endmodule

// File: rtl/lsr_hold_bank.sv
`timescale 1ns/1ps
module lsr_hold_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= src;
  end
endmodule

// File: rtl/lsr_latched_sipo.sv
`timescale 1ns/1ps
module lsr_latched_sipo
  import lsr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             sh_strobe,
  input  logic             st_strobe,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_drive,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  logic [SYNC_W-1:0] raw_in, synced;
  strobe_t           lvl, edges;
  logic              sh_fire, st_fire, clr_act;
  logic [WIDTH-1:0]  shift_q;
  logic [WIDTH-1:0]  hold_q;

  // Data goes through the same depth as the strobes so the two stay aligned
  always_comb begin
    raw_in          = '0;
    raw_in[IDX_SER] = ser_in;
    raw_in[IDX_SH]  = sh_strobe;
    raw_in[IDX_ST]  = st_strobe;
    raw_in[IDX_CLR] = clr_n;
  end

  lsr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  always_comb begin
    lvl.shift = synced[IDX_SH];
    lvl.store = synced[IDX_ST];
  end

  lsr_rise #(.W($bits(strobe_t))) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(edges)
  );

  assign sh_fire = edges.shift;
  assign st_fire = edges.store;
  assign clr_act = ~synced[IDX_CLR];

  lsr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr(clr_act), .step(sh_fire),
    .din(synced[IDX_SER]), .stages(shift_q)
  );

  // Same-cycle store samples the chain before its update (nonblocking)
  lsr_hold_bank #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(st_fire), .src(shift_q), .held(hold_q)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_pad
    assign par_q[b]     = hold_q[b];
    assign par_drive[b] = ~oe_n;
  end

  assign ser_out = shift_q[LAST];
endmodule

// File: rtl/lsr_latched_sipo_chk.sv
`timescale 1ns/1ps
module lsr_latched_sipo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic [WIDTH-1:0] par_q,
  input logic [WIDTH-1:0] par_drive,
  input logic             ser_out,
  input logic [WIDTH-1:0] shift_q,
  input logic             sh_fire,
  input logic             st_fire,
  input logic             clr_act
);
  a_r3_hold_only_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    !st_fire |=> $stable(par_q));

  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (shift_q == '0));

  a_r6_store_zero_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && shift_q == '0) |=> (par_q == '0));

  a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (par_drive == '0));

  a_r7_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (par_drive == '1));

  a_r9_serial_trails_stage6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_fire && !clr_act) |=> (ser_out == $past(shift_q[WIDTH-2])));

  a_r10_store_takes_preshift: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> (par_q == $past(shift_q)));
endmodule

bind lsr_latched_sipo lsr_latched_sipo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .par_q(par_q), .par_drive(par_drive),
  .ser_out(ser_out), .shift_q(shift_q), .sh_fire(sh_fire), .st_fire(st_fire),
  .clr_act(clr_act)
);

// File: tb/lsr_latched_sipo_test.sv
`timescale 1ns/1ps
module lsr_latched_sipo_test;
  logic clk = 1'b0;
  logic rst_n, din, sh, st, clr_n, oe_n;
  logic [7:0] h_q, h_drv, t_q, t_drv;
  logic h_so, t_so;
  int vectors = 0;
  int miscompares = 0;
  logic [7:0] m_head = '0, m_tail = '0, m_hh = '0, m_th = '0;

  always #2 clk = ~clk;

  lsr_latched_sipo uut (
    .clk(clk), .rst_n(rst_n), .ser_in(din), .sh_strobe(sh), .st_strobe(st),
    .clr_n(clr_n), .oe_n(oe_n), .par_q(h_q), .par_drive(h_drv), .ser_out(h_so)
  );

  lsr_latched_sipo uut_tail (
    .clk(clk), .rst_n(rst_n), .ser_in(h_so), .sh_strobe(sh), .st_strobe(st),
    .clr_n(clr_n), .oe_n(oe_n), .par_q(t_q), .par_drive(t_drv), .ser_out(t_so)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // One strobe pulse: 4 clocks high, 4 clocks low; model updated afterwards
  task automatic strobe(input logic do_sh, input logic do_st, input logic b);
    @(negedge clk);
    din = b; sh = do_sh; st = do_st;
    repeat (4) @(negedge clk);
    sh = 1'b0; st = 1'b0;
    repeat (4) @(negedge clk);
    if (do_st) begin m_hh = m_head; m_th = m_tail; end
    if (do_sh && clr_n) begin
      m_tail = {m_tail[6:0], m_head[7]};
      m_head = {m_head[6:0], b};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; din = 1'b0; sh = 1'b0; st = 1'b0; clr_n = 1'b1; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R2 reset par_q", h_q, 8'h00);
    chk("R7 reset drive on", h_drv, 8'hFF);
    chk("R9 reset ser_out", {7'b0, h_so}, 8'h00);

    // R1 R2 R9 R12: every byte value through the two-device chain
    for (int i = 0; i < 256; i++) begin
      logic [15:0] w;
      w = {8'(i), 8'(i) ^ 8'h5A};
      for (int j = 0; j < 16; j++) begin
        strobe(1'b1, 1'b0, w[15-j]);
        chk("R9 head ser_out", {7'b0, h_so}, {7'b0, m_head[7]});
      end
      strobe(1'b0, 1'b1, 1'b0);
      chk("R2 R1 head word", h_q, w[7:0]);
      chk("R12 tail word", t_q, w[15:8]);
      chk("R12 tail ser_out", {7'b0, t_so}, {7'b0, w[15]});
    end

    // R3: shifting without a store leaves parallel data alone
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R3 head unchanged", h_q, m_hh);
    chk("R3 tail unchanged", t_q, m_th);

    // R10: simultaneous strobes capture pre-shift contents
    strobe(1'b1, 1'b1, 1'b1);
    chk("R10 head pre-shift", h_q, m_hh);
    chk("R10 tail pre-shift", t_q, m_th);

    // R11: store latency of three sampling edges
    strobe(1'b1, 1'b0, ~m_hh[0]);
    @(negedge clk);
    st = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 not yet stored", h_q, m_hh);
    @(negedge clk);
    chk("R11 stored on third edge", h_q, m_head);
    st = 1'b0;
    repeat (4) @(negedge clk);
    m_hh = m_head; m_th = m_tail;

    // R7 R8: output enable only gates the drive flags
    @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
    chk("R7 drive off", h_drv, 8'h00);
    chk("R7 tail drive off", t_drv, 8'h00);
    chk("R8 ser_out kept", {7'b0, h_so}, {7'b0, m_head[7]});
    chk("R8 par_q kept while off", h_q, m_hh);
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R7 drive on", h_drv, 8'hFF);
    chk("R8 stored while disabled", h_q, m_hh);
    chk("R8 tail stored", t_q, m_th);

    // R4 R5 R6: clear
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    clr_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 ser_out cleared", {7'b0, h_so}, 8'h00);
    chk("R5 hold kept", h_q, m_hh);
    chk("R5 tail hold kept", t_q, m_th);
    strobe(1'b1, 1'b0, 1'b1);
    chk("R4 shift ignored", {7'b0, h_so}, 8'h00);
    m_head = '0; m_tail = '0;
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 hold kept after clear", h_q, m_hh);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R6 zeros stored", h_q, 8'h00);
    chk("R6 tail zeros stored", t_q, 8'h00);
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R1 shift after clear", h_q, 8'h01);

    finish_run();
  end
endmodule